// File: doc/BRIEF.md
# Image Sensor Readout Timing Generator

This block paces the readout of a CMOS image sensor. From a master clock it derives a slower internal tick. It then walks a rectangular window that is placed inside a fixed physical pixel array of 414 columns by 314 rows. For every window pixel it drives a row and column address. It passes the pixel byte that comes back through to the output while a combined line-sync / data-valid strobe is high. Each frame opens with a one-tick frame-sync pulse and a programmable vertical blanking gap. Each row is followed by a programmable horizontal blanking gap.

An exposure marker pulses during the first pixel of a programmable window row. A filtered enable input can pause the timing at any point and later resume it. A filtered active-low reset returns the block to the start of a frame. All configuration inputs are captured once per frame, so one frame never mixes two settings.

Top module: `sensor_timing`

## Requirements
- R1: A reset is taken only after `rstN` has been low for 8 consecutive master-clock edges. After that reset, `hsync`, `vsync` and `intStart` are low and the addresses sit at the window start. A low pulse on `rstN` of fewer than 8 edges changes nothing.
- R2: Within a frame the rows run in ascending order from the first row to the last row. Within each row the columns run in ascending order from the first column to the last column. While `hsync` is high, `pixOut` equals `pixIn`; while `hsync` is low, `pixOut` is 0.
- R3: A start value above the array limit (313 for rows, 413 for columns) is clamped to that limit. A size of 0 counts as 1. The last address is min(start + size - 1, limit).
- R4: `hsync` is high for exactly the active pixels of the window. Between two rows of one frame it is low for hBlank × (N+1) master clocks. With hBlank = 0 it stays high across the row change.
- R5: Each frame begins with `vsync` high for one tick, which is N+1 master clocks. After that come vBlank ticks before the first active pixel. `hsync` and `vsync` are never high together.
- R6: N is the 4-bit divider value. Every pixel is presented for exactly N+1 master clocks, and all timing advances only on that internal tick.
- R7: The enable level takes effect only after it has been held for 2 consecutive master clocks, so a one-clock glitch has no effect. While halted, `hsync`, `vsync` and `intStart` are low and the addresses hold. On re-enable, the scan resumes at the address where it stopped.
- R8: `intStart` is high during the first pixel of window row index T, counted from 0, where T is the 24-bit integration value. If T is not smaller than the number of window rows, there is no pulse.
- R9: Configuration inputs are captured at reset and at each frame boundary. A change during a frame takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low reset, filtered over 8 clocks |
| enable | input | 1 | Run (1) / halt (0), filtered over 2 clocks |
| cfgRowStart | input | 9 | Window first row |
| cfgColStart | input | 9 | Window first column |
| cfgHeight | input | 9 | Window height in rows |
| cfgWidth | input | 9 | Window width in columns |
| cfgHBlank | input | 16 | Blanking after each row, in ticks |
| cfgVBlank | input | 16 | Blanking after frame sync, in ticks |
| cfgIntTime | input | 24 | Window row index of the exposure marker |
| cfgClkDiv | input | 4 | Divider N, one tick per N+1 clocks |
| pixIn | input | 8 | Pixel byte for the current address |
| hsync | output | 1 | Line sync / data valid |
| vsync | output | 1 | Frame-start pulse |
| rowAddr | output | 9 | Current row address |
| colAddr | output | 9 | Current column address |
| pixOut | output | 8 | Pixel byte, zero outside active pixels |
| intStart | output | 1 | Exposure-start marker |

## Verification
The addresses, `hsync` and `vsync` change at the clock edge that ends a tick. `pixOut` and `intStart` follow within the same cycle. An enable change reaches the timing on the third edge after it is driven, and a reset is taken on the eighth low edge. The bench drives inputs and samples outputs on the falling clock edge. It measures every pixel run, every low gap and every frame-sync pulse in master clocks, and compares them with the values it expects for each frame. These expected values are computed from the configuration that frame captured. It checks halt behaviour only after the enable path has settled, and checks resumption before the next tick can move the address.

// File: rtl/tg_pkg.sv
package tg_pkg;

  typedef enum logic [1:0] {
    PH_VSYNC  = 2'd0,
    PH_VBLANK = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HBLANK = 2'd3
  } phase_t;

  // strobes from the sequencer to the address/data path
  typedef struct packed {
    logic tick;       // internal clock enable
    logic frameLoad;  // capture configuration, restart window
    logic colStep;    // next column in the current row
    logic rowStep;    // next row, column back to first
    logic active;     // an active pixel is being presented
  } tgStrobe_t;

endpackage

// File: rtl/tg_axis.sv
module tg_axis #(
  parameter int POS_W = 9,
  parameter int LIMIT = 414
) (
  input  logic             clk,
  input  logic             load,
  input  logic             step,
  input  logic             restart,
  input  logic [POS_W-1:0] cfgStart,
  input  logic [POS_W-1:0] cfgSize,
  output logic [POS_W-1:0] addr,
  output logic             isFirst,
  output logic             isLast
);
  localparam int EXT_W = POS_W + 1;
  localparam logic [POS_W-1:0] TOP_P = POS_W'(LIMIT - 1);
  localparam logic [EXT_W-1:0] TOP_E = EXT_W'(LIMIT - 1);

  logic [POS_W-1:0] firstQ, lastQ, startC, sizeC, lastC;
  logic [EXT_W-1:0] endExt;

  always_comb begin
    startC = (cfgStart > TOP_P) ? TOP_P : cfgStart;
    sizeC  = (cfgSize == '0) ? POS_W'(1) : cfgSize;
    endExt = {1'b0, startC} + {1'b0, sizeC} - EXT_W'(1);
    lastC  = (endExt > TOP_E) ? TOP_P : endExt[POS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (load) begin
      firstQ <= startC;
      lastQ  <= lastC;
      addr   <= startC;
    end else if (step) begin
      addr <= addr + 1'b1;
    end else if (restart) begin
      addr <= firstQ;
    end
  end

  assign isFirst = (addr == firstQ);
  assign isLast  = (addr == lastQ);
endmodule

// File: rtl/tg_control.sv
module tg_control
  import tg_pkg::*;
#(
  parameter int BLANK_W  = 16,
  parameter int DIV_W    = 4,
  parameter int RST_HOLD = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [BLANK_W-1:0] hBlank,
  input  logic [BLANK_W-1:0] vBlank,
  input  logic [DIV_W-1:0]   clkDiv,
  input  logic               colLast,
  input  logic               rowLast,
  output logic               coreRst,
  output logic               running,
  output tgStrobe_t          strb,
  output logic               hsync,
  output logic               vsync
);
  localparam int RC_W = $clog2(RST_HOLD + 1);
  localparam logic [RC_W-1:0] RC_MAX = RC_W'(RST_HOLD - 1);

  logic [RC_W-1:0]    rstCnt;
  logic [1:0]         enSync;
  logic [DIV_W-1:0]   divCnt;
  logic [BLANK_W-1:0] bCnt, bNxt;
  phase_t             phase, phaseNxt;
  logic               tick, rowDone;
  tgStrobe_t          s;

  // reset qualifier: taken on the RST_HOLD-th consecutive low edge
  always_ff @(posedge clk) begin
    if (rstN)                rstCnt <= '0;
    else if (rstCnt != RC_MAX) rstCnt <= rstCnt + 1'b1;
  end
  assign coreRst = !rstN && (rstCnt == RC_MAX);

  // enable qualifier: level must agree on two samples
  always_ff @(posedge clk) begin
    if (coreRst) begin
      enSync  <= '0;
      running <= 1'b0;
    end else begin
      enSync <= {enSync[0], enable};
      if (&enSync)       running <= 1'b1;
      else if (~|enSync) running <= 1'b0;
    end
  end

  // clock divider, frozen while halted
  assign tick = running && (divCnt == clkDiv);
  always_ff @(posedge clk) begin
    if (coreRst)      divCnt <= '0;
    else if (running) divCnt <= tick ? '0 : divCnt + 1'b1;
  end

  assign hsync = running && (phase == PH_ACTIVE);
  assign vsync = running && (phase == PH_VSYNC);

  always_comb begin
    phaseNxt    = phase;
    bNxt        = bCnt;
    rowDone     = 1'b0;
    s           = '0;
    s.tick      = tick;
    s.active    = hsync;
    if (tick) begin
      case (phase)
        PH_VSYNC: begin
          if (vBlank == '0) phaseNxt = PH_ACTIVE;
          else begin phaseNxt = PH_VBLANK; bNxt = vBlank - 1'b1; end
        end
        PH_VBLANK: begin
          if (bCnt == '0) phaseNxt = PH_ACTIVE;
          else            bNxt = bCnt - 1'b1;
        end
        PH_ACTIVE: begin
          if (!colLast)           s.colStep = 1'b1;
          else if (hBlank == '0) rowDone = 1'b1;
          else begin phaseNxt = PH_HBLANK; bNxt = hBlank - 1'b1; end
        end
        PH_HBLANK: begin
          if (bCnt == '0) rowDone = 1'b1;
          else            bNxt = bCnt - 1'b1;
        end
        default: phaseNxt = PH_VSYNC;
      endcase
    end
    if (rowDone) begin
      if (rowLast) begin phaseNxt = PH_VSYNC;  s.frameLoad = 1'b1; end
      else         begin phaseNxt = PH_ACTIVE; s.rowStep   = 1'b1; end
    end
  end

  always_ff @(posedge clk) begin
    if (coreRst) begin
      phase <= PH_VSYNC;
      bCnt  <= '0;
    end else begin
      phase <= phaseNxt;
      bCnt  <= bNxt;
    end
  end

  assign strb = s;
endmodule

// File: rtl/tg_datapath.sv
module tg_datapath
  import tg_pkg::*;
#(
  parameter int COLS    = 414,
  parameter int ROWS    = 314,
  parameter int POS_W   = 9,
  parameter int BLANK_W = 16,
  parameter int INT_W   = 24,
  parameter int DIV_W   = 4,
  parameter int PIX_W   = 8
) (
  input  logic               clk,
  input  logic               coreRst,
  input  tgStrobe_t          strb,
  input  logic [POS_W-1:0]   cfgRowStart,
  input  logic [POS_W-1:0]   cfgColStart,
  input  logic [POS_W-1:0]   cfgHeight,
  input  logic [POS_W-1:0]   cfgWidth,
  input  logic [BLANK_W-1:0] cfgHBlank,
  input  logic [BLANK_W-1:0] cfgVBlank,
  input  logic [INT_W-1:0]   cfgIntTime,
  input  logic [DIV_W-1:0]   cfgClkDiv,
  input  logic [PIX_W-1:0]   pixIn,
  output logic [BLANK_W-1:0] hBlankQ,
  output logic [BLANK_W-1:0] vBlankQ,
  output logic [DIV_W-1:0]   clkDivQ,
  output logic               colLast,
  output logic               rowLast,
  output logic [POS_W-1:0]   rowAddr,
  output logic [POS_W-1:0]   colAddr,
  output logic [PIX_W-1:0]   pixOut,
  output logic               intStart
);
  logic             load, colFirst, rowFirstUnused;
  logic [INT_W-1:0] intCnt;
  logic             intArmed;

  assign load = coreRst || strb.frameLoad;

  tg_axis #(.POS_W(POS_W), .LIMIT(COLS)) u_col (
    .clk(clk), .load(load), .step(strb.colStep), .restart(strb.rowStep),
    .cfgStart(cfgColStart), .cfgSize(cfgWidth),
    .addr(colAddr), .isFirst(colFirst), .isLast(colLast)
  );

  tg_axis #(.POS_W(POS_W), .LIMIT(ROWS)) u_row (
    .clk(clk), .load(load), .step(strb.rowStep), .restart(1'b0),
    .cfgStart(cfgRowStart), .cfgSize(cfgHeight),
    .addr(rowAddr), .isFirst(rowFirstUnused), .isLast(rowLast)
  );

  always_ff @(posedge clk) begin
    if (load) begin
      hBlankQ  <= cfgHBlank;
      vBlankQ  <= cfgVBlank;
      clkDivQ  <= cfgClkDiv;
      intCnt   <= cfgIntTime;
      intArmed <= 1'b1;
    end else if (strb.tick && strb.active && colFirst) begin
      if (intCnt == '0) intArmed <= 1'b0;
      else              intCnt   <= intCnt - 1'b1;
    end
  end

  assign intStart = strb.active && colFirst && intArmed && (intCnt == '0);
  assign pixOut   = strb.active ? pixIn : '0;
endmodule

// File: rtl/sensor_timing.sv
module sensor_timing
  import tg_pkg::*;
#(
  parameter int COLS     = 414,
  parameter int ROWS     = 314,
  parameter int POS_W    = 9,
  parameter int BLANK_W  = 16,
  parameter int INT_W    = 24,
  parameter int DIV_W    = 4,
  parameter int PIX_W    = 8,
  parameter int RST_HOLD = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [POS_W-1:0]   cfgRowStart,
  input  logic [POS_W-1:0]   cfgColStart,
  input  logic [POS_W-1:0]   cfgHeight,
  input  logic [POS_W-1:0]   cfgWidth,
  input  logic [BLANK_W-1:0] cfgHBlank,
  input  logic [BLANK_W-1:0] cfgVBlank,
  input  logic [INT_W-1:0]   cfgIntTime,
  input  logic [DIV_W-1:0]   cfgClkDiv,
  input  logic [PIX_W-1:0]   pixIn,
  output logic               hsync,
  output logic               vsync,
  output logic [POS_W-1:0]   rowAddr,
  output logic [POS_W-1:0]   colAddr,
  output logic [PIX_W-1:0]   pixOut,
  output logic               intStart
);
  tgStrobe_t          strb;
  logic               coreRst, running, colLast, rowLast;
  logic [BLANK_W-1:0] hBlankQ, vBlankQ;
  logic [DIV_W-1:0]   clkDivQ;

  tg_control #(.BLANK_W(BLANK_W), .DIV_W(DIV_W), .RST_HOLD(RST_HOLD)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .hBlank(hBlankQ), .vBlank(vBlankQ), .clkDiv(clkDivQ),
    .colLast(colLast), .rowLast(rowLast),
    .coreRst(coreRst), .running(running), .strb(strb),
    .hsync(hsync), .vsync(vsync)
  );

  tg_datapath #(.COLS(COLS), .ROWS(ROWS), .POS_W(POS_W), .BLANK_W(BLANK_W),
                .INT_W(INT_W), .DIV_W(DIV_W), .PIX_W(PIX_W)) u_dp (
    .clk(clk), .coreRst(coreRst), .strb(strb),
    .cfgRowStart(cfgRowStart), .cfgColStart(cfgColStart),
    .cfgHeight(cfgHeight), .cfgWidth(cfgWidth),
    .cfgHBlank(cfgHBlank), .cfgVBlank(cfgVBlank),
    .cfgIntTime(cfgIntTime), .cfgClkDiv(cfgClkDiv), .pixIn(pixIn),
    .hBlankQ(hBlankQ), .vBlankQ(vBlankQ), .clkDivQ(clkDivQ),
    .colLast(colLast), .rowLast(rowLast),
    .rowAddr(rowAddr), .colAddr(colAddr), .pixOut(pixOut), .intStart(intStart)
  );
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
  parameter int COLS  = 414,
  parameter int ROWS  = 314,
  parameter int POS_W = 9
) (
  input logic             clk,
  input logic             coreRst,
  input logic             running,
  input logic             hsync,
  input logic             vsync,
  input logic             intStart,
  input logic [POS_W-1:0] rowAddr,
  input logic [POS_W-1:0] colAddr
);
  // R5: line and frame strobes never overlap
  a_r5_sync_exclusive: assert property (@(posedge clk) disable iff (coreRst)
    !(hsync && vsync));

  // R7: a settled halt freezes the scan position
  a_r7_halt_freeze: assert property (@(posedge clk) disable iff (coreRst)
    (!running && $past(!running)) |-> ($stable(rowAddr) && $stable(colAddr)));

  // R8: exposure marker only during an active pixel
  a_r8_marker_active: assert property (@(posedge clk) disable iff (coreRst)
    intStart |-> hsync);

  // R3: active addresses stay inside the physical array
  a_r3_in_array: assert property (@(posedge clk) disable iff (coreRst)
    hsync |-> (int'(rowAddr) < ROWS && int'(colAddr) < COLS));

  // R2: within a row the column only moves up by one
  a_r2_col_ascend: assert property (@(posedge clk) disable iff (coreRst)
    (hsync && $past(hsync) && rowAddr == $past(rowAddr) && colAddr != $past(colAddr))
      |-> colAddr == $past(colAddr) + 1'b1);
endmodule

bind sensor_timing tg_checker #(.COLS(COLS), .ROWS(ROWS), .POS_W(POS_W)) u_chk (
  .clk(clk), .coreRst(coreRst), .running(running), .hsync(hsync), .vsync(vsync),
  .intStart(intStart), .rowAddr(rowAddr), .colAddr(colAddr)
);

// File: tb/sensor_timing_test.sv
module sensor_timing_test;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 314;
  localparam int COLS = 414;

  typedef struct { int rs, cs, h, w, hb, vb, it, dv; } cfg_t;
  typedef struct { int row, col, pix, run, gap, vs; bit intS; } item_t;

  logic        clk = 1'b0;
  logic        rstN, enable;
  logic [8:0]  cfgRowStart, cfgColStart, cfgHeight, cfgWidth;
  logic [15:0] cfgHBlank, cfgVBlank;
  logic [23:0] cfgIntTime;
  logic [3:0]  cfgClkDiv;
  logic [7:0]  pixIn, pixOut;
  logic        hsync, vsync, intStart;
  logic [8:0]  rowAddr, colAddr;

  int checks = 0, errors = 0;
  bit runDone = 0;
  bit monOn = 0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // stand-in for the pixel array: counter-like pattern from the address
  assign pixIn = {rowAddr[3:0], colAddr[3:0]} ^ 8'h5A;

  sensor_timing uut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgRowStart(cfgRowStart), .cfgColStart(cfgColStart),
    .cfgHeight(cfgHeight), .cfgWidth(cfgWidth),
    .cfgHBlank(cfgHBlank), .cfgVBlank(cfgVBlank),
    .cfgIntTime(cfgIntTime), .cfgClkDiv(cfgClkDiv), .pixIn(pixIn),
    .hsync(hsync), .vsync(vsync), .rowAddr(rowAddr), .colAddr(colAddr),
    .pixOut(pixOut), .intStart(intStart)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!runDone) begin
      runDone = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic int minI(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int pixOf(input int r, input int c);
    return (((r & 15) << 4) | (c & 15)) ^ 8'h5A;
  endfunction

  task automatic applyCfg(input cfg_t c);
    cfgRowStart = 9'(c.rs); cfgColStart = 9'(c.cs);
    cfgHeight = 9'(c.h); cfgWidth = 9'(c.w);
    cfgHBlank = 16'(c.hb); cfgVBlank = 16'(c.vb);
    cfgIntTime = 24'(c.it); cfgClkDiv = 4'(c.dv);
  endtask

  // driver: expected pixels of one frame (R2, R3, R4, R5, R6, R8)
  task automatic pushFrame(input cfg_t c, input cfg_t p, input bit first);
    int fr, lr, fc, lc;
    item_t it;
    fr = minI(c.rs, ROWS-1); lr = minI(fr + ((c.h == 0) ? 1 : c.h) - 1, ROWS-1);
    fc = minI(c.cs, COLS-1); lc = minI(fc + ((c.w == 0) ? 1 : c.w) - 1, COLS-1);
    for (int r = fr; r <= lr; r++) begin
      for (int col = fc; col <= lc; col++) begin
        it.row = r; it.col = col; it.pix = pixOf(r, col);
        it.run = c.dv + 1;
        it.intS = (col == fc) && (r - fr == c.it);
        it.vs = -1;
        it.gap = 0;
        if (col == fc) begin
          if (r != fr) it.gap = c.hb * (c.dv + 1);
          else begin
            it.vs = c.dv + 1;
            it.gap = first ? -1 : p.hb * (p.dv + 1) + (1 + c.vb) * (c.dv + 1);
          end
        end
        q.push_back(it);
      end
    end
  endtask

  // monitor: pops and compares as pixels appear
  int runLen = 0, lastRun = 0, gapCnt = 0, vsCnt = 0;
  bit prevH = 0, prevV = 0, havePix = 0, curInt = 0;
  int prevRow = -1, prevCol = -1;
  always @(negedge clk) begin
    if (monOn) begin
      if (vsync) vsCnt = prevV ? vsCnt + 1 : 1;
      if (hsync) begin
        if (!prevH || int'(rowAddr) != prevRow || int'(colAddr) != prevCol) begin
          if (havePix) check(runLen == lastRun, "R6", "pixel length", runLen, lastRun);
          if (q.size() == 0) begin
            check(0, "R2", "unexpected pixel row", int'(rowAddr), -1);
          end else begin
            item_t it;
            it = q.pop_front();
            check(int'(rowAddr) == it.row, "R2", "row", int'(rowAddr), it.row);
            check(int'(colAddr) == it.col, "R2", "col", int'(colAddr), it.col);
            check(int'(pixOut) == it.pix, "R2", "pixel", int'(pixOut), it.pix);
            check(intStart == it.intS, "R8", "marker", int'(intStart), int'(it.intS));
            if (it.gap >= 0) check(gapCnt == it.gap, (it.vs >= 0) ? "R5" : "R4",
                                   "gap", gapCnt, it.gap);
            if (it.vs >= 0) check(vsCnt == it.vs, "R5", "frame sync length", vsCnt, it.vs);
            lastRun = it.run;
            curInt = it.intS;
          end
          runLen = 1; gapCnt = 0; havePix = 1;
        end else begin
          runLen++;
          check(intStart == curInt, "R8", "marker held", int'(intStart), int'(curInt));
        end
      end else begin
        gapCnt++;
        check(pixOut == 8'd0, "R2", "pixel outside active", int'(pixOut), 0);
      end
      prevH = hsync; prevV = vsync;
      prevRow = int'(rowAddr); prevCol = int'(colAddr);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    cfg_t cA, cB, cC;
    int holdRow, holdCol;
    cA = '{rs: 2,   cs: 5,   h: 3, w: 4,  hb: 2, vb: 3, it: 1, dv: 0};
    cB = '{rs: 311, cs: 500, h: 5, w: 3,  hb: 0, vb: 0, it: 0, dv: 2}; // R3 clamps
    cC = '{rs: 0,   cs: 0,   h: 3, w: 20, hb: 1, vb: 2, it: 5, dv: 3};
    rstN = 1'b1; enable = 1'b1;
    applyCfg(cA);
    repeat (2) @(negedge clk);
    rstN = 1'b0;
    repeat (10) @(negedge clk);
    // R1: reset state
    check(hsync == 1'b0, "R1", "hsync in reset", int'(hsync), 0);
    check(vsync == 1'b0, "R1", "vsync in reset", int'(vsync), 0);
    check(intStart == 1'b0, "R1", "marker in reset", int'(intStart), 0);
    check(rowAddr == 9'd2, "R1", "row in reset", int'(rowAddr), 2);
    check(colAddr == 9'd5, "R1", "col in reset", int'(colAddr), 5);
    pushFrame(cA, cA, 1);
    monOn = 1;
    rstN = 1'b1;

    // R9: change settings mid-frame; takes effect next frame
    do @(negedge clk); while (!hsync);
    applyCfg(cB);
    pushFrame(cB, cA, 0);
    // R1: short reset pulse must be ignored (monitor would see disruption)
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    do @(negedge clk); while (!vsync);
    do @(negedge clk); while (!hsync);
    applyCfg(cC);
    pushFrame(cC, cB, 0);

    do @(negedge clk); while (!vsync);
    do @(negedge clk); while (!hsync);
    // R7: one-clock enable glitch has no effect
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;

    do @(negedge clk); while (!vsync);
    monOn = 0;
    check(q.size() == 0, "R9", "expected pixels left", q.size(), 0);

    // R7: halt and resume
    do @(negedge clk); while (!(hsync && colAddr == 9'd0));
    enable = 1'b0;
    repeat (5) @(negedge clk);
    holdRow = int'(rowAddr); holdCol = int'(colAddr);
    check(hsync == 1'b0, "R7", "hsync halted", int'(hsync), 0);
    check(vsync == 1'b0, "R7", "vsync halted", int'(vsync), 0);
    check(intStart == 1'b0, "R7", "marker halted", int'(intStart), 0);
    repeat (6) @(negedge clk);
    check(int'(rowAddr) == holdRow, "R7", "row frozen", int'(rowAddr), holdRow);
    check(int'(colAddr) == holdCol, "R7", "col frozen", int'(colAddr), holdCol);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check(hsync == 1'b1, "R7", "hsync resumed", int'(hsync), 1);
    check(int'(colAddr) == holdCol, "R7", "col on resume", int'(colAddr), holdCol);
    check(int'(rowAddr) == holdRow, "R7", "row on resume", int'(rowAddr), holdRow);
    finishRun();
  end
endmodule